// File: doc/BRIEF.md
# Convergent rounding word reducer

This block shrinks a wide signed two's-complement sample, typically the full-precision result of a FIR filter, down to a 16-bit signed word for the next stage of an up- or down-conversion datapath. A fixed number of low-order bits, set by a parameter, are treated as the fractional part of the value and removed. The remaining integer part is rounded to the nearest value. When the fraction is exactly one half, the block picks the even neighbour. Ties therefore go up half of the time and down half of the time, and the long-run DC error stays at zero. Plain truncation and round-half-away-from-zero both leave a DC error.

A sample enters together with a valid strobe. One clock later the rounded, saturated word appears on the output register with its own valid strobe. Results that do not fit in 16 signed bits are clamped to the nearest limit. The input width and the number of dropped bits are parameters, so one block can be placed at several points of the datapath.

Top module: `cvg_round16`

## Requirements
- R1: While reset is applied, and for as long as the internally synchronised reset stays low, out_vld is 0 and out_data is 0.
- R2: out_vld is high in exactly the cycle after the clock edge on which in_vld was sampled high. Each accepted sample produces one output word.
- R3: If the dropped fraction is greater than one half, the output is floor(x)+1. In bit terms, the bit just below the kept LSB is 1 and at least one lower dropped bit is 1. Examples: 5.75 gives 6, and -5.25 gives -5.
- R4: If the dropped fraction is below one half (first dropped bit 0), the output is floor(x), the value the kept bits already hold. Examples: 5.25 gives 5, and 7.0 gives 7.
- R5: If the dropped fraction is exactly one half (first dropped bit 1, all lower dropped bits 0), the output is the even one of floor(x) and floor(x)+1. Examples: 2.5 gives 2, 1.5 gives 2, 3.5 gives 4, -2.5 gives -2, -1.5 gives -2, and ±0.5 gives 0.
- R6: A rounded result above 32767 outputs 0x7FFF, including a result that only overflows because of rounding (32767.5 gives 0x7FFF). A non-negative input never gives an output with bit 15 set.
- R7: A rounded result below -32768 outputs 0x8000 (-32769.0 and -32768.75 both give 0x8000). A negative input always gives an output that is negative or zero.
- R8: In a cycle where in_vld is low, out_data keeps its previous value whatever in_data carries, and out_vld goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input word; its low DROP bits are the fraction |
| out_vld | output | 1 | Output word strobe |
| out_data | output | OUT_W | Rounded and saturated signed result (16 bits by default) |

## Verification
Fractions just below, exactly at and just above one half are applied on both sides of zero. These separate nearest rounding from truncation, and they show whether the tie rule follows the kept LSB rather than the sign. Both kept-LSB parities are used at the tie. This distinguishes round-half-even from round-half-up and from round-half-away-from-zero. Values near ±32768, including ties that only overflow once rounded, together with the extreme input codes, exercise the clamp. A long run of random words, sent back to back and with gaps, checks alignment, and idle cycles with toggling input data check that the output is held.

// File: rtl/cvg_round_pkg.sv
package cvg_round_pkg;

  // Increment decision for nearest rounding with even-tie resolution.
  // guard  : first bit below the kept LSB
  // sticky : OR of every bit below the guard bit
  // lsb    : kept LSB
  function automatic logic round_up(input logic guard, input logic sticky, input logic lsb);
    return guard & (sticky | lsb);
  endfunction

endpackage

// File: rtl/cvg_rst_sync.sv
module cvg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_q_n = stage_q[1];
endmodule

// File: rtl/cvg_round_decide.sv
module cvg_round_decide #(
  parameter int IN_W = 32,
  parameter int DROP = 8,
  localparam int KEEP_W = IN_W - DROP
) (
  input  logic [IN_W-1:0]   word_i,
  output logic [KEEP_W:0]   sum_o
);
  import cvg_round_pkg::*;

  logic [KEEP_W-1:0] kept;
  logic              inc;

  assign kept = word_i[IN_W-1:DROP];

  generate
    if (DROP == 0) begin : g_none
      assign inc = 1'b0;
    end else if (DROP == 1) begin : g_guard_only
      assign inc = round_up(word_i[0], 1'b0, word_i[1]);
    end else begin : g_full
      logic sticky;
      assign sticky = |word_i[DROP-2:0];
      assign inc    = round_up(word_i[DROP-1], sticky, word_i[DROP]);
    end
  endgenerate

  // One guard bit on top so the increment never wraps.
  assign sum_o = {kept[KEEP_W-1], kept} + {{KEEP_W{1'b0}}, inc};
endmodule

// File: rtl/cvg_round_clip.sv
module cvg_round_clip #(
  parameter int SUM_W = 25,
  parameter int OUT_W = 16
) (
  input  logic [SUM_W-1:0] sum_i,
  output logic [OUT_W-1:0] data_o
);
  generate
    if (SUM_W >= OUT_W) begin : g_clamp
      logic [SUM_W-OUT_W:0] top;
      logic                 fits;
      assign top  = sum_i[SUM_W-1:OUT_W-1];
      assign fits = (&top) | ~(|top);
      always_comb begin
        if (fits)                  data_o = sum_i[OUT_W-1:0];
        else if (sum_i[SUM_W-1])   data_o = {1'b1, {(OUT_W-1){1'b0}}};
        else                       data_o = {1'b0, {(OUT_W-1){1'b1}}};
      end
    end else begin : g_extend
      assign data_o = {{(OUT_W-SUM_W){sum_i[SUM_W-1]}}, sum_i};
    end
  endgenerate
endmodule

// File: rtl/cvg_round16.sv
module cvg_round16 #(
  parameter int IN_W  = 32,
  parameter int DROP  = 8,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_vld,
  output logic [OUT_W-1:0] out_data
);
  localparam int KEEP_W = IN_W - DROP;
  localparam int SUM_W  = KEEP_W + 1;

  logic             rst_q_n;
  logic [SUM_W-1:0] sum;
  logic [OUT_W-1:0] clipped;
  logic             vld_d, vld_q;
  logic [OUT_W-1:0] data_d, data_q;

  cvg_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cvg_round_decide #(.IN_W(IN_W), .DROP(DROP)) u_dec (
    .word_i (in_data),
    .sum_o  (sum)
  );

  cvg_round_clip #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_clip (
    .sum_i  (sum),
    .data_o (clipped)
  );

  always_comb begin
    vld_d  = in_vld;
    data_d = data_q;
    if (in_vld) data_d = clipped;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_data = data_q;
endmodule

// File: rtl/cvg_round16_chk.sv
module cvg_round16_chk #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             in_vld,
  input logic [IN_W-1:0]  in_data,
  input logic             out_vld,
  input logic [OUT_W-1:0] out_data
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_q_n |-> (!out_vld && out_data == '0)); // R1
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q_n) in_vld |=> out_vld); // R2
  AST_VLD_DROPS:   assert property (@(posedge clk) disable iff (!rst_q_n) !in_vld |=> !out_vld); // R2
  AST_HOLD_IDLE:   assert property (@(posedge clk) disable iff (!rst_q_n) !in_vld |=> $stable(out_data)); // R8
  AST_POS_STAYS_POS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_vld && !in_data[IN_W-1]) |=> !out_data[OUT_W-1]); // R6
  AST_NEG_STAYS_NEG: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_vld && in_data[IN_W-1]) |=> (out_data[OUT_W-1] || out_data == '0)); // R7
endmodule

bind cvg_round16 cvg_round16_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .in_vld   (in_vld),
  .in_data  (in_data),
  .out_vld  (out_vld),
  .out_data (out_data)
);

// File: tb/tb_cvg_round16.sv
module tb_cvg_round16;
  localparam int IN_W  = 32;
  localparam int DROP  = 8;
  localparam int OUT_W = 16;

  typedef struct {
    logic [OUT_W-1:0] exp;
    string            tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_vld = 1'b0;
  logic [IN_W-1:0]  in_data = '0;
  logic             out_vld;
  logic [OUT_W-1:0] out_data;

  item_t queue_q[$];
  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  logic  exp_vld = 1'b0;
  logic  mon_on = 1'b0;
  logic [OUT_W-1:0] last_exp = '0;

  cvg_round16 #(.IN_W(IN_W), .DROP(DROP), .OUT_W(OUT_W)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_data  (in_data),
    .out_vld  (out_vld),
    .out_data (out_data)
  );

  always #5 clk = ~clk;

  function automatic logic [OUT_W-1:0] model(input longint v);
    longint fl, fr, half, r;
    fl   = v >>> DROP;
    fr   = v & ((64'sd1 <<< DROP) - 1);
    half = 64'sd1 <<< (DROP - 1);
    r    = fl;
    if (fr > half) r = fl + 1;
    else if (fr == half && fl[0]) r = fl + 1;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r[OUT_W-1:0];
  endfunction

  task automatic check(input string tag, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input longint v, input string tag);
    item_t it;
    @(negedge clk);
    in_vld  = 1'b1;
    in_data = v[IN_W-1:0];
    it.exp  = model(v);
    it.tag  = tag;
    last_exp = it.exp;
    queue_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld  = 1'b0;
      in_data = $urandom;
    end
  endtask

  // Bench-side view of the one-cycle strobe delay
  always @(posedge clk) exp_vld <= in_vld;

  // Monitor
  always @(negedge clk) begin
    if (mon_on) begin
      check("R2 strobe", {15'd0, out_vld}, {15'd0, exp_vld});
      if (out_vld) begin
        if (queue_q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected output actual %h expected none", out_data);
        end else begin
          item_t it;
          it = queue_q.pop_front();
          check(it.tag, out_data, it.exp);
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 vld in reset", {15'd0, out_vld}, 16'd0);
    check("R1 data in reset", out_data, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 vld in sync release", {15'd0, out_vld}, 16'd0);
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    // R4: below half
    send(longint'(5 * 256 + 64), "R4 5.25");
    send(longint'(7 * 256), "R4 7.0");
    send(longint'(-6 * 256 + 127), "R4 -5.50390625");
    // R3: above half
    send(longint'(5 * 256 + 192), "R3 5.75");
    send(longint'(5 * 256 + 129), "R3 5.50390625");
    send(longint'(-6 * 256 + 192), "R3 -5.25");
    // R5: ties
    send(longint'(2 * 256 + 128), "R5 2.5");
    send(longint'(1 * 256 + 128), "R5 1.5");
    send(longint'(3 * 256 + 128), "R5 3.5");
    send(longint'(-3 * 256 + 128), "R5 -2.5");
    send(longint'(-2 * 256 + 128), "R5 -1.5");
    send(longint'(128), "R5 0.5");
    send(longint'(-128), "R5 -0.5");
    idle(2);
    // R6: positive clamp
    send(longint'(40000) * 256, "R6 40000");
    send(longint'(32767) * 256 + 128, "R6 32767.5");
    send(longint'(32767) * 256 + 64, "R6 32767.25");
    send(longint'(32766) * 256 + 128, "R6 32766.5");
    send(longint'(32'h7FFF_FFFF), "R6 max code");
    // R7: negative clamp
    send(longint'(-40000) * 256, "R7 -40000");
    send(longint'(-32769) * 256, "R7 -32769");
    send(longint'(-32769) * 256 + 64, "R7 -32768.75");
    send(longint'(-32769) * 256 + 128, "R7 -32768.5");
    send(-longint'(64'sd2147483648), "R7 min code");
    idle(3);

    // R8: held output while idle with toggling input data
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_vld  = 1'b0;
      in_data = $urandom;
      check("R8 hold", out_data, last_exp);
      check("R8 vld low", {15'd0, out_vld}, 16'd0);
    end

    // Random sweep, mixed spacing
    for (int i = 0; i < 300; i++) begin
      longint v;
      v = longint'($signed($urandom));
      if (i % 3 == 0) v = v >>> 10;
      send(v, "R3 random");
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
    end
    idle(4);
    check("R2 all outputs seen", 16'(queue_q.size()), 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule